// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Slave

This block is the slave end of a two-wire serial memory that answers reads. It runs on a fast system clock and oversamples the bus clock (SCL) and data (SDA) lines. It does not drive SDA high. It only pulls the line low through an enable output, and the board's open-drain wiring resolves the level. The block finds start and stop conditions and checks a fixed 4-bit device-type code. It takes in a two-byte word address and keeps an address counter that steps through a fixed-content byte array.

A master sets the counter with an address-entry transfer. A stop right after the address only loads the counter. A repeated start followed by a read turns the same transfer into a random read. A read that comes with no address entry begins at the counter's current value. Each acknowledged byte asks for the next location. The counter wraps at the top of the array.

Top module: `sser_slave`

## Requirements
- R1: A start is SDA falling while SCL is high. It begins device-code reception from any state. A stop is SDA rising while SCL is high. It returns the block to standby with SDA released.
- R2: The first byte after a start carries the device code 4'b1010 in bits 7:4, ignored bits in 3:1, and the read/write flag in bit 0 (1 = read), sent MSB first. On a match the slave holds SDA low through the ninth clock. On a mismatch it leaves SDA released and returns to standby.
- R3: In standby the slave acknowledges nothing and drives nothing until a start arrives.
- R4: With the flag at 0, two word-address bytes follow, high byte first, and each is acknowledged. Bits 7:4 of the high byte are ignored. The address is {high[3:0], low}.
- R5: The counter loads when the low address byte is received. A stop at that point leaves the new address in the counter and sends no data. A stop before the low byte leaves the counter unchanged.
- R6: A repeated start followed by a read, after the address bytes, returns the byte at the address just loaded.
- R7: A read with no address entry before it returns the byte at the current counter value.
- R8: The counter advances by one after each transmitted byte. Each master acknowledge produces the byte at the next address.
- R9: The counter wraps from 12'hFFF to 12'h000 in the middle of a sequential read.
- R10: A missing master acknowledge ends the read. The slave releases SDA and sends nothing more until a new start.
- R11: The slave changes its SDA enable only while SCL is low. Data bits go out MSB first.
- R12: The byte stored at address a is a[7:0] ^ a[11:4] ^ 8'hA5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock as sampled from the line |
| sda_i | input | 1 | Bus data as sampled from the line |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The assertions check the following on every cycle. The SDA enable only rises or falls while the synchronized SCL is low. A start always leads to device-code reception, and a stop always leads to a released, idle slave. A wrong device code never gets an acknowledge. The counter moves up by exactly one each time a byte has been sent, and this includes the wrap. The directed scenarios cover the rest, because it depends on what a whole transfer means:
- which address a random, current-address or sequential read returns;
- that a stop after the address loads the counter but a stop before the low byte does not;
- that the upper address bits are ignored;
- that nothing is sent after a missing acknowledge.

// File: rtl/sser_slave.sv
module sser_slave #(
  parameter int AW  = 12,
  parameter logic [3:0] DEV = 4'b1010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_ADEV, S_AHI, S_AAHI, S_ALO, S_AALO, S_HOLD, S_TX, S_MACK, S_NEXT
  } st_t;

  st_t st;
  logic [2:0] scl_q, sda_q;
  logic [7:0] sh, hi;
  logic [3:0] cnt;
  logic [AW-1:0] addr;
  logic rw;
  logic [15:0] full;

  wire scl   = scl_q[1];
  wire scl_d = scl_q[2];
  wire sda   = sda_q[1];
  wire sda_d = sda_q[2];
  wire rise  = scl & ~scl_d;
  wire fall  = ~scl & scl_d;
  wire start_det = scl & scl_d & sda_d & ~sda;
  wire stop_det  = scl & scl_d & ~sda_d & sda;
  wire [7:0] dout = addr[7:0] ^ addr[AW-1:AW-8] ^ 8'hA5;

  assign full = {hi, sh};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= S_IDLE;
      sh     <= '0;
      hi     <= '0;
      cnt    <= '0;
      addr   <= '0;
      rw     <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      st     <= S_DEV;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        S_DEV, S_AHI, S_ALO: begin
          if (rise) begin
            sh  <= {sh[6:0], sda};
            cnt <= cnt + 4'd1;
          end else if (fall && cnt == 4'd8) begin
            cnt <= '0;
            if (st == S_DEV) begin
              if (sh[7:4] == DEV) begin
                rw     <= sh[0];
                sda_oe <= 1'b1;
                st     <= S_ADEV;
              end else begin
                st <= S_IDLE;
              end
            end else if (st == S_AHI) begin
              hi     <= sh;
              sda_oe <= 1'b1;
              st     <= S_AAHI;
            end else begin
              addr   <= full[AW-1:0];
              sda_oe <= 1'b1;
              st     <= S_AALO;
            end
          end
        end
        S_ADEV: if (fall) begin
          if (rw) begin
            sh     <= dout;
            sda_oe <= ~dout[7];
            cnt    <= '0;
            st     <= S_TX;
          end else begin
            sda_oe <= 1'b0;
            st     <= S_AHI;
          end
        end
        S_AAHI: if (fall) begin
          sda_oe <= 1'b0;
          st     <= S_ALO;
        end
        S_AALO: if (fall) begin
          sda_oe <= 1'b0;
          st     <= S_HOLD;
        end
        S_TX: begin
          if (rise) cnt <= cnt + 4'd1;
          else if (fall) begin
            if (cnt == 4'd8) begin
              sda_oe <= 1'b0;
              addr   <= addr + 1'b1;
              cnt    <= '0;
              st     <= S_MACK;
            end else begin
              sh     <= {sh[6:0], 1'b0};
              sda_oe <= ~sh[6];
            end
          end
        end
        S_MACK: if (rise) st <= sda ? S_IDLE : S_NEXT;
        S_NEXT: if (fall) begin
          sh     <= dout;
          sda_oe <= ~dout[7];
          cnt    <= '0;
          st     <= S_TX;
        end
        default: ;
      endcase
    end
endmodule

module sser_slave_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_oe,
  input logic          scl,
  input logic          fall,
  input logic          start_det,
  input logic          stop_det,
  input logic [3:0]    st,
  input logic [3:0]    cnt,
  input logic [7:0]    sh,
  input logic [AW-1:0] addr
);
  localparam logic [3:0] C_IDLE = 4'd0, C_DEV = 4'd1, C_TX = 4'd8, C_MACK = 4'd9;

  p_oe_rise_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl);
  p_oe_fall_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl);
  p_start_dev_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> st == C_DEV);
  p_stop_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !start_det) |=> (st == C_IDLE && !sda_oe));
  p_bad_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_DEV && fall && cnt == 4'd8 && sh[7:4] != 4'b1010 && !start_det && !stop_det)
      |=> (st == C_IDLE && !sda_oe));
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st == C_IDLE |-> !sda_oe);
  p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == C_TX && st == C_MACK) |-> addr == AW'($past(addr) + 1'b1));
endmodule

bind sser_slave sser_slave_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl(scl), .fall(fall),
  .start_det(start_det), .stop_det(stop_det), .st(st), .cnt(cnt),
  .sh(sh), .addr(addr)
);

// File: tb/test_sser_slave.sv
`timescale 1ns/1ps
module test_sser_slave;
  localparam time Q = 40ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  int total = 0;
  int bad = 0;
  int oe_hi_changes = 0;
  logic [11:0] exp_addr;

  always #2.5ns clk = ~clk;

  sser_slave i_sser_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  always @(sda_oe) if (rst_n && scl === 1'b1) oe_hi_changes++;

  function automatic logic [7:0] mem(input logic [11:0] a);
    return a[7:0] ^ a[11:4] ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; #Q; scl = 1'b1; #Q; sda_m = 1'b0; #Q; scl = 1'b0; #Q;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; #Q; scl = 1'b1; #Q; sda_m = 1'b1; #Q;
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q;
    end
    sda_m = 1'b1; #Q; scl = 1'b1; #Q; ack = !sda_line; #Q; scl = 1'b0; #Q;
  endtask

  task automatic rd_byte(input bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; #Q; scl = 1'b1; #Q; b[i] = sda_line; #Q; scl = 1'b0; #Q;
    end
    sda_m = !give_ack; #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q;
    sda_m = 1'b1;
  endtask

  task automatic set_addr(input logic [7:0] h, input logic [7:0] l, input string tag);
    bit a;
    bus_start;
    wr_byte(8'hA0, a); chk(a, {tag, " dev ack"}, a, 1);
    wr_byte(h, a);     chk(a, {tag, " R4 hi ack"}, a, 1);
    wr_byte(l, a);     chk(a, {tag, " R4 lo ack"}, a, 1);
  endtask

  task automatic cur_read(input string tag);
    bit a;
    logic [7:0] d;
    bus_start;
    wr_byte(8'hA1, a); chk(a, {tag, " read ack"}, a, 1);
    rd_byte(1'b0, d);  chk(d == mem(exp_addr), tag, d, mem(exp_addr));
    exp_addr++;
    bus_stop;
  endtask

  task automatic t_reset;
    chk(sda_oe == 1'b0, "R1 reset releases SDA", sda_oe, 0);
  endtask

  task automatic t_bad_code;
    bit a;
    bus_start;
    wr_byte(8'h51, a); chk(!a, "R2 wrong code not acked", a, 0);
    wr_byte(8'hA0, a); chk(!a, "R3 standby ignores byte", a, 0);
    bus_stop;
    chk(oe_hi_changes == 0, "R11 no drive change with SCL high", oe_hi_changes, 0);
  endtask

  task automatic t_addr_load;
    set_addr(8'h01, 8'h23, "load");
    bus_stop;
    exp_addr = 12'h123;
    cur_read("R5 R7 read after address load");
    cur_read("R8 current read continues");
  endtask

  task automatic t_partial_stop;
    bit a;
    bus_start;
    wr_byte(8'hA0, a); wr_byte(8'h07, a);
    bus_stop;
    cur_read("R5 stop before low byte keeps counter");
  endtask

  task automatic t_random;
    bit a;
    logic [7:0] d;
    set_addr(8'hF8, 8'h9C, "rand");
    exp_addr = 12'h89C;
    bus_start;
    wr_byte(8'hA1, a); chk(a, "R6 read ack", a, 1);
    rd_byte(1'b0, d);  chk(d == mem(exp_addr), "R6 R4 R12 random read", d, mem(exp_addr));
    exp_addr++;
    bus_stop;
  endtask

  task automatic t_seq_wrap;
    bit a;
    logic [7:0] d;
    set_addr(8'h0F, 8'hFD, "seq");
    exp_addr = 12'hFFD;
    bus_start;
    wr_byte(8'hA1, a);
    for (int k = 0; k < 5; k++) begin
      rd_byte(k < 4, d);
      chk(d == mem(exp_addr), (exp_addr < 12'hFFD) ? "R9 wrapped byte" : "R8 sequential byte",
          d, mem(exp_addr));
      exp_addr++;
    end
    rd_byte(1'b0, d);
    chk(d == 8'hFF, "R10 nothing sent after nack", d, 8'hFF);
    bus_stop;
    cur_read("R8 R9 counter after wrap");
  endtask

  initial begin
    #(100000 * 5ns);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #23ns; rst_n = 1'b1; #50ns;
    t_reset;
    t_bad_code;
    t_addr_load;
    t_partial_stop;
    t_random;
    t_seq_wrap;
    chk(oe_hi_changes == 0, "R11 drive changes only with SCL low", oe_hi_changes, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule